// File: doc/BRIEF.md
# Parallel Configuration Byte Intake

This block takes configuration bytes from an eight-bit parallel port and hands each accepted byte to a downstream sink as a one-cycle push. An external host can drive the port, or in master mode the block can pace reads from an external memory itself. A handshake line tells the host when a new byte may be written. Its meaning depends on the selected mode.

When the stream is compressed, each accepted byte keeps the port occupied for a fixed expansion window of `EXP_CYCLES` clocks. The expansion is modelled only by this delay. When the stream is uncompressed, the port can take a byte on every clock. A read strobe with the chip select active puts five status flags on the upper data bits. In master mode the block produces a memory read strobe on every clock for plain streams, and once per expansion window for compressed streams.

Top module: `cfg_byte_intake`

## Requirements
- R1: After reset the block is in its idle state:
  - no push is pending;
  - the overflow flag is clear;
  - no expansion window is open.
- R2: In peripheral mode (`mode_i` = 0), `busy_o` is high exactly when the port is ready. The port is ready when no expansion window is open and `sink_full_i` is low.
- R3: In slave parallel mode (`mode_i` = 1), `busy_o` follows the ready condition only when `compress_i` is high. With `compress_i` low, `busy_o` is held high.
- R4: In modes 0 and 1, a write is `cs_n_i` low together with `wr_n_i` low in a cycle with no open expansion window and the sink not full. A write is accepted at that clock edge. In the next cycle `push_o` is high for one cycle and `push_data_o` holds the byte that was on `data_i`.
- R5: With `compress_i` high, an accepted byte opens an expansion window. The port is then not ready for the following `EXP_CYCLES`-1 cycles, and write strobes in those cycles produce no push.
- R6: With `compress_i` low, bytes are accepted on consecutive cycles, one per clock.
- R7: An acceptance attempt while `sink_full_i` is high drops the byte, produces no push, and sets a sticky overflow flag. The flag clears only at reset.
- R8: While `cs_n_i` and `rd_n_i` are both low, `data_oe_o` is high and `data_o[7:3]` carries status. The bits, from 7 down to 3, are: ready, overflow, `crc_err_i`, `done_i`, expansion window open. Otherwise `data_oe_o` is low and `data_o` is zero. `data_o[2:0]` is always zero.
- R9: In master mode (`mode_i` = 2):
  - `mem_rd_tick_o` is high on every cycle when `compress_i` is low.
  - When `compress_i` is high, it is high once every `EXP_CYCLES` cycles, starting in the first compressed master cycle.
  - A byte is taken on each tick while the port is idle, and `cs_n_i`/`wr_n_i` are ignored.
  - `busy_o` is high.
  - Outside master mode the tick is low.
- R10: Mode 3 is off: no byte is accepted, `busy_o` is low, and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 peripheral, 1 slave parallel, 2 master, 3 off |
| compress_i | input | 1 | Stream is compressed |
| cs_n_i | input | 1 | Active-low chip select |
| wr_n_i | input | 1 | Active-low write strobe |
| rd_n_i | input | 1 | Active-low read strobe |
| data_i | input | 8 | Incoming byte |
| crc_err_i | input | 1 | CRC error flag from downstream |
| done_i | input | 1 | Configuration done flag |
| sink_full_i | input | 1 | Downstream sink cannot take a byte |
| busy_o | output | 1 | Handshake line, meaning per mode |
| data_oe_o | output | 1 | Drive enable for data bits 7..3 |
| data_o | output | 8 | Status read-back value |
| push_o | output | 1 | One-cycle push into the sink |
| push_data_o | output | 8 | Byte being pushed |
| mem_rd_tick_o | output | 1 | Memory read strobe in master mode |

## Verification
The bench raises the read strobe and the write strobe together under one chip select, so a status read and a byte acceptance fall in the same cycle. It then checks that the status shows the state from before the edge, with ready still high and the expansion bit still low. It also checks that the push and the closed ready bit appear one cycle later.

A second collision is a write arriving while the sink is full in uncompressed slave parallel mode. In that mode the handshake does not hold the host off. The check is that no push appears and that the overflow bit reads back high on the very next read.

// File: rtl/cfg_intake_pkg.sv
package cfg_intake_pkg;

  typedef enum logic [1:0] {
    MODE_PERIPH    = 2'd0,
    MODE_SLAVE_PAR = 2'd1,
    MODE_MASTER    = 2'd2,
    MODE_OFF       = 2'd3
  } cfg_mode_e;

  // Level of the handshake line for a given mode and ready condition.
  function automatic logic handshake_level(cfg_mode_e m, logic comp, logic ready);
    case (m)
      MODE_PERIPH:    return ready;
      MODE_SLAVE_PAR: return comp ? ready : 1'b1;
      MODE_MASTER:    return 1'b1;
      default:        return 1'b0;
    endcase
  endfunction

  // Status word shown on the upper data bits, bit 7 first.
  function automatic logic [4:0] pack_status(logic ready, logic ovf, logic crc,
                                             logic done, logic expanding);
    return {ready, ovf, crc, done, expanding};
  endfunction

endpackage

// File: rtl/cfg_pace.sv
module cfg_pace #(
  parameter int EXP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic comp_i,
  input  logic full_i,
  output logic accept_o,
  output logic overflow_o,
  output logic idle_o,
  output logic expanding_o
);
  localparam int CW = (EXP_CYCLES > 2) ? $clog2(EXP_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(EXP_CYCLES - 1);

  logic [CW-1:0] occ_q;
  logic          attempt_w;

  assign idle_o      = (occ_q == '0);
  assign expanding_o = !idle_o;
  assign attempt_w   = strobe_i && idle_o;
  assign accept_o    = attempt_w && !full_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q      <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (attempt_w && full_i) overflow_o <= 1'b1;
      if (accept_o)            occ_q <= comp_i ? LOAD : '0;
      else if (!idle_o)        occ_q <= occ_q - 1'b1;
    end
  end
endmodule

// File: rtl/cfg_rclk_gen.sv
module cfg_rclk_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic comp_i,
  output logic tick_o
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;
  logic          slow_w;

  assign slow_w = en_i && comp_i;
  assign tick_o = en_i && (!comp_i || div_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                div_q <= '0;
    else if (!slow_w)          div_q <= '0;
    else if (div_q == LAST)    div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/cfg_status_port.sv
module cfg_status_port
  import cfg_intake_pkg::*;
(
  input  logic       cs_n_i,
  input  logic       rd_n_i,
  input  logic       ready_i,
  input  logic       ovf_i,
  input  logic       crc_i,
  input  logic       done_i,
  input  logic       expanding_i,
  output logic       oe_o,
  output logic [7:0] data_o
);
  logic [4:0] stat_w;

  assign stat_w = pack_status(ready_i, ovf_i, crc_i, done_i, expanding_i);
  assign oe_o   = !cs_n_i && !rd_n_i;
  assign data_o = oe_o ? {stat_w, 3'b000} : 8'h00;
endmodule

// File: rtl/cfg_byte_intake.sv
module cfg_byte_intake
  import cfg_intake_pkg::*;
#(
  parameter int EXP_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       compress_i,
  input  logic       cs_n_i,
  input  logic       wr_n_i,
  input  logic       rd_n_i,
  input  logic [7:0] data_i,
  input  logic       crc_err_i,
  input  logic       done_i,
  input  logic       sink_full_i,
  output logic       busy_o,
  output logic       data_oe_o,
  output logic [7:0] data_o,
  output logic       push_o,
  output logic [7:0] push_data_o
  , output logic     mem_rd_tick_o
);
  cfg_mode_e mode_w;
  logic      strobe_w, accept_w, overflow_w, idle_w, expanding_w, ready_w;
  logic      master_w;

  assign mode_w   = cfg_mode_e'(mode_i);
  assign master_w = (mode_w == MODE_MASTER);

  cfg_rclk_gen #(.DIV(EXP_CYCLES)) u_rclk (
    .clk(clk), .rst_n(rst_n), .en_i(master_w), .comp_i(compress_i),
    .tick_o(mem_rd_tick_o)
  );

  always_comb begin
    case (mode_w)
      MODE_PERIPH, MODE_SLAVE_PAR: strobe_w = !cs_n_i && !wr_n_i;
      MODE_MASTER:                 strobe_w = mem_rd_tick_o;
      default:                     strobe_w = 1'b0;
    endcase
  end

  cfg_pace #(.EXP_CYCLES(EXP_CYCLES)) u_pace (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_w), .comp_i(compress_i),
    .full_i(sink_full_i), .accept_o(accept_w), .overflow_o(overflow_w),
    .idle_o(idle_w), .expanding_o(expanding_w)
  );

  assign ready_w = idle_w && !sink_full_i;
  assign busy_o  = handshake_level(mode_w, compress_i, ready_w);

  cfg_status_port u_stat (
    .cs_n_i(cs_n_i), .rd_n_i(rd_n_i), .ready_i(ready_w), .ovf_i(overflow_w),
    .crc_i(crc_err_i), .done_i(done_i), .expanding_i(expanding_w),
    .oe_o(data_oe_o), .data_o(data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_o      <= 1'b0;
      push_data_o <= 8'h00;
    end else begin
      push_o <= accept_w;
      if (accept_w) push_data_o <= data_i;
    end
  end
endmodule

// File: rtl/cfg_intake_chk.sv
module cfg_intake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       compress_i,
  input logic [7:0] data_i,
  input logic       sink_full_i,
  input logic       busy_o,
  input logic       data_oe_o,
  input logic [7:0] data_o,
  input logic       push_o,
  input logic [7:0] push_data_o,
  input logic       mem_rd_tick_o,
  input logic       overflow_w
);
  AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> push_data_o == $past(data_i)); // R4
  AST_EXPAND_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && $past(compress_i) && mode_i == 2'd0) |-> !busy_o); // R5
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> $past(!sink_full_i)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow_w) |-> overflow_w); // R7
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe_o |-> data_o == 8'h00); // R8
  AST_D7_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && mode_i == 2'd0) |-> data_o[7] == busy_o); // R8
  AST_TICK_MASTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != 2'd2) |-> !mem_rd_tick_o); // R9
  AST_OFF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == 2'd3) |-> !push_o); // R10
endmodule

bind cfg_byte_intake cfg_intake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .compress_i(compress_i),
  .data_i(data_i), .sink_full_i(sink_full_i), .busy_o(busy_o),
  .data_oe_o(data_oe_o), .data_o(data_o), .push_o(push_o),
  .push_data_o(push_data_o), .mem_rd_tick_o(mem_rd_tick_o),
  .overflow_w(overflow_w)
);

// File: tb/sim_cfg_byte_intake.sv
`timescale 1ns/1ps
module sim_cfg_byte_intake;
  localparam int EXP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic comp = 1'b0, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic crc = 1'b0, done = 1'b0, full = 1'b0;
  logic busy, oe, push, tick;
  logic [7:0] dout, pdata;

  cfg_byte_intake #(.EXP_CYCLES(EXP)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .compress_i(comp), .cs_n_i(cs_n),
    .wr_n_i(wr_n), .rd_n_i(rd_n), .data_i(din), .crc_err_i(crc), .done_i(done),
    .sink_full_i(full), .busy_o(busy), .data_oe_o(oe), .data_o(dout),
    .push_o(push), .push_data_o(pdata), .mem_rd_tick_o(tick)
  );

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cycles = 0;
  string phase = "R1";

  // Behavioural reference state
  int   m_occ = 0, m_div = 0;
  bit   m_ovf = 0, m_push = 0;
  logic [7:0] m_pdata = 8'h00;
  logic [7:0] push_log[$];

  function automatic bit m_tick();
    if (mode != 2'd2) return 0;
    return comp ? (m_div == 0) : 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_occ = 0; m_div = 0; m_ovf = 0; m_push = 0; m_pdata = 8'h00;
    end else begin
      bit t, s, att;
      t = m_tick();
      s = (mode <= 2'd1) ? (!cs_n && !wr_n) : ((mode == 2'd2) ? t : 1'b0);
      att = s && (m_occ == 0);
      m_push = att && !full;
      if (m_push) begin m_pdata = din; push_log.push_back(din); end
      if (att && full) m_ovf = 1;
      if (m_push) m_occ = comp ? EXP - 1 : 0;
      else if (m_occ > 0) m_occ = m_occ - 1;
      if (mode == 2'd2 && comp) m_div = (m_div + 1) % EXP; else m_div = 0;
    end
  end

  task automatic chk(string req, string sig, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, sig, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit rdy, eb, eoe;
    logic [7:0] ed;
    string breq;
    rdy = (m_occ == 0) && !full;
    case (mode)
      2'd0: begin eb = rdy; breq = "R2"; end
      2'd1: begin eb = comp ? rdy : 1'b1; breq = "R3"; end
      2'd2: begin eb = 1'b1; breq = "R9"; end
      default: begin eb = 1'b0; breq = "R10"; end
    endcase
    eoe = !cs_n && !rd_n;
    ed = eoe ? {rdy, m_ovf, crc, done, (m_occ != 0), 3'b000} : 8'h00;
    chk({phase, "/", breq}, "busy_o", {7'd0, busy}, {7'd0, eb});
    chk({phase, "/R4"}, "push_o", {7'd0, push}, {7'd0, m_push});
    if (m_push) chk({phase, "/R4"}, "push_data_o", pdata, m_pdata);
    chk({phase, "/R9"}, "mem_rd_tick_o", {7'd0, tick}, {7'd0, m_tick()});
    chk({phase, "/R8"}, "data_oe_o", {7'd0, oe}, {7'd0, eoe});
    chk({phase, "/R8"}, "data_o", dout, ed);
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(logic [7:0] b);
    cs_n = 1'b0; wr_n = 1'b0; din = b;
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    phase = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk("R1", "push_o after reset", {7'd0, push}, 8'd0);

    // R6: uncompressed peripheral back-to-back writes, with concurrent read
    phase = "R6";
    for (int i = 0; i < 5; i++) begin
      wr(8'hA0 + 8'(i)); rd_n = (i == 2) ? 1'b0 : 1'b1;
      cyc(1);
    end
    idle_bus(); cyc(2);
    chk("R6", "bytes pushed", 8'(push_log.size()), 8'd5);

    // R5: compressed peripheral, host hammers the strobe through the window
    phase = "R5";
    comp = 1'b1; crc = 1'b1;
    wr(8'h5A); rd_n = 1'b0;          // read and write in the same cycle
    cyc(1);
    for (int i = 0; i < 12; i++) begin wr(8'h60 + 8'(i)); cyc(1); end
    idle_bus(); cyc(EXP);
    chk("R5", "bytes pushed", 8'(push_log.size()), 8'd7);

    // R2: sink full holds the peripheral handshake low
    phase = "R2";
    comp = 1'b0; full = 1'b1; rd_n = 1'b0; cs_n = 1'b0;
    cyc(3);
    idle_bus(); full = 1'b0; cyc(1);

    // R7: slave parallel uncompressed overflows on a full sink
    phase = "R7";
    mode = 2'd1; full = 1'b1;
    wr(8'hEE); cyc(2);
    wr_n = 1'b1; rd_n = 1'b0; cyc(1);
    full = 1'b0; done = 1'b1; cyc(2);
    chk("R7", "bytes pushed", 8'(push_log.size()), 8'd7);
    idle_bus();

    // R3: slave parallel compressed uses the handshake
    phase = "R3";
    comp = 1'b1;
    for (int i = 0; i < 18; i++) begin wr(8'h30 + 8'(i)); cyc(1); end
    comp = 1'b0;
    for (int i = 0; i < 3; i++) begin wr(8'h40 + 8'(i)); cyc(1); end
    idle_bus(); cyc(EXP);

    // R9: master mode, plain then compressed, with stray strobes
    phase = "R9";
    mode = 2'd2; comp = 1'b0;
    for (int i = 0; i < 4; i++) begin din = 8'h90 + 8'(i); cyc(1); end
    comp = 1'b1; cs_n = 1'b0; wr_n = 1'b0;
    for (int i = 0; i < 3 * EXP; i++) begin din = 8'hC0 + 8'(i); cyc(1); end
    full = 1'b1; cyc(EXP + 1); full = 1'b0;
    idle_bus(); comp = 1'b0; cyc(EXP);

    // R10: off mode ignores everything
    phase = "R10";
    mode = 2'd3;
    for (int i = 0; i < 6; i++) begin wr(8'h11 + 8'(i)); cyc(1); end
    idle_bus(); crc = 1'b0; done = 1'b0;
    rd_n = 1'b0; cs_n = 1'b0; cyc(2); idle_bus(); cyc(1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule